// File: doc/BRIEF.md
# UART Automatic Flow-Control Generator

This block produces the hardware handshake signals that sit beside a UART with an 8-entry receive FIFO. It holds an 8-bit control register. From that register it drives the enable qualifiers for the receiver and the transmitter. It also decides the level of the RTS pin and whether the transmitter may begin its next character.

When automatic RTS is on, the block compares the free space left in the receive FIFO with a programmed threshold. It drops RTS as soon as the free space reaches that threshold, so the far end stops sending. When automatic RTS is off, the pin follows a software modem-control bit.

When automatic CTS is on, an inactive CTS input raises a hold signal that keeps the transmitter from starting a new character. A character already being shifted out still completes. The CTS input passes through a two-stage synchronizer first. RTS and CTS polarity can each be inverted on its own.

Top module: `uart_flow_ctrl`

## Requirements
- R1: On reset the control register reads 8'h03 (receiver and transmitter enabled, all other bits zero), and `rts_pin` and `tx_hold` are 0.
- R2: `rx_en` equals control bit 0 and `tx_en` equals control bit 1, from the clock after the register is written.
- R3: With control bit 2 set (automatic RTS), free = 8 − `rx_count`. RTS is asserted while free exceeds the threshold and deasserted while free is less than or equal to it. `rts_pin` reflects the inputs one clock later.
- R4: Control bits 5:4 select the threshold in free entries: code 00 gives 3, 01 gives 2, 10 gives 1 and 11 gives 4.
- R5: With automatic RTS, `rts_pin` is 1 when RTS is asserted and control bit 6 is 0. Setting bit 6 inverts the pin level.
- R6: With control bit 2 clear, `rts_pin` follows `sw_rts` one clock later, and control bit 6 has no effect.
- R7: With control bit 3 set (automatic CTS), CTS is active when `cts_pin` XOR control bit 7 is 1. `tx_hold` is 1 while CTS is inactive and `tx_busy` is 0. The CTS level passes two synchronizer flops before it has any effect.
- R8: While `tx_busy` is 1, `tx_hold` stays 0 even when CTS is inactive, so the character in flight completes.
- R9: With control bit 3 clear, `tx_hold` is 0 whatever `cts_pin` is.
- R10: Control bit 7 inverts the sense of `cts_pin` for automatic CTS.
- R11: RTS has no hysteresis. When the fill count falls back below the deassert point, RTS is reasserted on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Current control register value |
| rx_count | input | CNT_W (4) | Receive FIFO fill count, 0 to 8 |
| sw_rts | input | 1 | Software RTS level used when automatic RTS is off |
| cts_pin | input | 1 | CTS pin, asynchronous |
| tx_busy | input | 1 | A character is currently being shifted out |
| rts_pin | output | 1 | RTS pin level |
| rx_en | output | 1 | Receiver enable qualifier |
| tx_en | output | 1 | Transmitter enable qualifier |
| tx_hold | output | 1 | Blocks the start of the next transmit character |

## Verification
The block holds only three pieces of state: the control register, the registered RTS level and the CTS synchronizer. A corrupted control bit appears at `rx_en`, `tx_en` or `ctl_rdata` on the next clock. It appears at `rts_pin` one clock after that. A wrong threshold decode or a wrong free-space count shows up only at the exact fill level where the decision flips. For that reason every threshold code is driven on both sides of its boundary. A synchronizer of the wrong depth moves `tx_hold` earlier or later than two clocks after a CTS edge.

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
  parameter int FIFO_DEPTH = 8,
  parameter int CTS_SYNC = 2,
  parameter logic [7:0] CTL_RESET = 8'h03,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  output logic [7:0]       ctl_rdata,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             sw_rts,
  input  logic             cts_pin,
  input  logic             tx_busy,
  output logic             rts_pin,
  output logic             rx_en,
  output logic             tx_en,
  output logic             tx_hold
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);

  logic [7:0]          ctl_q;
  logic [CTS_SYNC-1:0] cts_sync;
  logic [CNT_W-1:0]    free_cnt, thr;
  logic                room_ok, cts_active, armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_q <= CTL_RESET;
    else if (ctl_we) ctl_q <= ctl_wdata;

  assign ctl_rdata = ctl_q;
  assign rx_en = ctl_q[0];
  assign tx_en = ctl_q[1];

  assign free_cnt = (rx_count >= DEPTH_C) ? '0 : DEPTH_C - rx_count;

  always_comb
    case (ctl_q[5:4])
      2'b00:   thr = CNT_W'(3);
      2'b01:   thr = CNT_W'(2);
      2'b10:   thr = CNT_W'(1);
      default: thr = CNT_W'(4);
    endcase

  assign room_ok = free_cnt > thr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rts_pin <= 1'b0;
    else rts_pin <= ctl_q[2] ? (room_ok ^ ctl_q[6]) : sw_rts;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cts_sync <= '0;
    else cts_sync <= {cts_sync[CTS_SYNC-2:0], cts_pin};

  assign cts_active = cts_sync[CTS_SYNC-1] ^ ctl_q[7];
  assign tx_hold = ctl_q[3] & ~cts_active & ~tx_busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else armed <= 1'b1;

  // R1: register leaves reset holding its reset value
  a_r1_reset_value: assert property (@(posedge clk)
    $rose(rst_n) |-> ctl_rdata == CTL_RESET);

  // R3: a full FIFO always leaves RTS deasserted under automatic RTS
  a_r3_full_drops_rts: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(ctl_q[2]) && $past(rx_count) == DEPTH_C
      |-> rts_pin == $past(ctl_q[6]));

  // R3: an empty FIFO always leaves RTS asserted under automatic RTS
  a_r3_empty_keeps_rts: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(ctl_q[2]) && $past(rx_count) == '0
      |-> rts_pin != $past(ctl_q[6]));

  // R6: software RTS path when automatic RTS is off
  a_r6_sw_rts_follow: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(ctl_q[2]) |-> rts_pin == $past(sw_rts));
endmodule

// File: tb/tb_uart_flow_ctrl.sv
module tb_uart_flow_ctrl;
  logic clk = 0, rst_n = 0, ctl_we = 0, sw_rts = 0, cts_pin = 0, tx_busy = 0;
  logic [7:0] ctl_wdata = 0, ctl_rdata;
  logic [3:0] rx_count = 0;
  logic rts_pin, rx_en, tx_en, tx_hold;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_flow_ctrl dut (.clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .rx_count(rx_count), .sw_rts(sw_rts), .cts_pin(cts_pin),
    .tx_busy(tx_busy), .rts_pin(rts_pin), .rx_en(rx_en), .tx_en(tx_en), .tx_hold(tx_hold));

  function automatic logic [31:0] mk(logic [7:0] c, logic [3:0] n, logic cts, logic busy,
      logic sw, logic ertsv, logic eh, logic erx, logic etx, logic [7:0] tag);
    return {c, n, cts, busy, sw, ertsv, eh, erx, etx, 5'd0, tag};
  endfunction

  localparam int NV = 24;
  localparam logic [31:0] VEC [NV] = '{
    mk(8'h07,4'd4,0,0,0,1,0,1,1,8'd3),  // R3 free4>3
    mk(8'h07,4'd5,0,0,0,0,0,1,1,8'd3),  // R3 free3<=3
    mk(8'h07,4'd8,0,0,0,0,0,1,1,8'd3),  // R3 full
    mk(8'h17,4'd5,0,0,0,1,0,1,1,8'd4),  // R4 code01 thr2
    mk(8'h17,4'd6,0,0,0,0,0,1,1,8'd4),  // R4
    mk(8'h27,4'd6,0,0,0,1,0,1,1,8'd4),  // R4 code10 thr1
    mk(8'h27,4'd7,0,0,0,0,0,1,1,8'd4),  // R4
    mk(8'h37,4'd3,0,0,0,1,0,1,1,8'd4),  // R4 code11 thr4
    mk(8'h37,4'd4,0,0,0,0,0,1,1,8'd4),  // R4
    mk(8'h47,4'd4,0,0,0,0,0,1,1,8'd5),  // R5 inverted asserted
    mk(8'h47,4'd5,0,0,0,1,0,1,1,8'd5),  // R5 inverted deasserted
    mk(8'h03,4'd8,0,0,1,1,0,1,1,8'd6),  // R6 sw high
    mk(8'h03,4'd0,0,0,0,0,0,1,1,8'd6),  // R6 sw low
    mk(8'h43,4'd0,0,0,1,1,0,1,1,8'd6),  // R6 bit6 ignored
    mk(8'h0B,4'd0,1,0,0,0,0,1,1,8'd7),  // R7 cts active
    mk(8'h0B,4'd0,0,0,0,0,1,1,1,8'd7),  // R7 cts inactive
    mk(8'h0B,4'd0,0,1,0,0,0,1,1,8'd8),  // R8 busy
    mk(8'h8B,4'd0,1,0,0,0,1,1,1,8'd10), // R10 inverted inactive
    mk(8'h8B,4'd0,0,0,0,0,0,1,1,8'd10), // R10 inverted active
    mk(8'h03,4'd0,0,0,0,0,0,1,1,8'd9),  // R9 auto-CTS off
    mk(8'h00,4'd0,0,0,0,0,0,0,0,8'd2),  // R2
    mk(8'h01,4'd0,0,0,0,0,0,1,0,8'd2),  // R2
    mk(8'h02,4'd0,0,0,0,0,0,0,1,8'd2),  // R2
    mk(8'h08,4'd0,0,0,0,0,1,0,0,8'd9)   // R9 contrast: hold with bit3 set
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ctl", ctl_rdata, 8'h03);
    chk("R1 rts", {7'd0, rts_pin}, 8'd0);
    chk("R1 hold", {7'd0, tx_hold}, 8'd0);
    chk("R2 en", {6'd0, rx_en, tx_en}, 8'h03);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      wr(v[31:24]);
      rx_count = v[23:20]; cts_pin = v[19]; tx_busy = v[18]; sw_rts = v[17];
      repeat (3) @(negedge clk);
      chk($sformatf("R%0d rts vec%0d", v[7:0], i), {7'd0, rts_pin}, {7'd0, v[16]});
      chk($sformatf("R%0d hold vec%0d", v[7:0], i), {7'd0, tx_hold}, {7'd0, v[15]});
      chk($sformatf("R%0d en vec%0d", v[7:0], i), {6'd0, rx_en, tx_en}, {6'd0, v[14:13]});
    end

    // R3 latency and R11 no hysteresis
    wr(8'h07); rx_count = 5; tx_busy = 0;
    repeat (2) @(negedge clk);
    chk("R3 deassert", {7'd0, rts_pin}, 8'd0);
    rx_count = 4;
    @(negedge clk);
    chk("R11 reassert next clock", {7'd0, rts_pin}, 8'd1);
    rx_count = 5;
    @(negedge clk);
    chk("R3 one-clock drop", {7'd0, rts_pin}, 8'd0);

    // R7 synchronizer depth: two clocks from CTS edge
    wr(8'h0B); cts_pin = 1;
    repeat (3) @(negedge clk);
    cts_pin = 0;
    @(negedge clk);
    chk("R7 after one edge", {7'd0, tx_hold}, 8'd0);
    @(negedge clk);
    chk("R7 after two edges", {7'd0, tx_hold}, 8'd1);
    tx_busy = 1;
    #1 chk("R8 busy clears hold", {7'd0, tx_hold}, 8'd0);

    // R1 mid-run reset restores register
    wr(8'hF4);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 re-reset", ctl_rdata, 8'h03);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule